// File: doc/BRIEF.md
# Tree Magnitude Comparator

This block decides whether one unsigned operand is strictly larger than another. Every bit position produces a two-bit code of its own: a "greater" flag and a "defer" flag. Defer means the bit pair is equal, so the decision has to come from lower bits. A balanced tree of two-bit selectors then combines neighbouring groups level by level. The upper group's code is passed on unless it defers, in which case the lower group's code goes up instead. At the root only the greater flag is used. The result is a depth of log2(WIDTH) selector levels in place of a ripple chain of WIDTH stages.

A parameter picks how the tree is timed:

- Mode 0 is purely combinational.
- Mode 1 places a register after every merge level.
- Mode 2 places a register after every second merge level and after the last one.

In the pipelined modes a new operand pair can enter on every cycle. A valid flag travels through the same registers as the data and marks each result.

Top module: `tree_gt_cmp`

## Requirements
- R1: `gt` is 1 exactly when unsigned `a` is greater than unsigned `b`, and 0 when `a` is less than or equal to `b`.
- R2: Each bit position i yields a code (greater, defer):
  - `a[i]==b[i]` gives (0,1).
  - `a[i]<b[i]` gives (0,0).
  - `a[i]>b[i]` gives (1,0).
  - The pair (1,1) never occurs at any node of the tree.
- R3: A merge node forwards the code of its more significant input when that code's defer flag is 0, and otherwise forwards the less significant input. As a result, the most significant differing bit decides `gt`.
- R4: When `a` equals `b`, every node defers, the root code is (0,1) and `gt` is 0.
- R5: With PIPE_MODE 0 there are no registers: `gt` and `out_valid` follow `a`, `b` and `in_valid` within the same cycle.
- R6: With PIPE_MODE 1 a register follows each of the log2(WIDTH) levels. The latency is log2(WIDTH) cycles (3 at WIDTH 8), and a new pair is accepted every cycle.
- R7: With PIPE_MODE 2 a register follows every odd-numbered level (levels counted from 0 at the leaves) and the final level. The latency is ceil(log2(WIDTH)/2) cycles (2 at WIDTH 8), and a new pair is accepted every cycle.
- R8: `out_valid` repeats `in_valid` delayed by the latency, in step with the `gt` it qualifies. While `rst_n` is low, and until the first valid pair has crossed the pipeline, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| in_valid | input | 1 | Marks `a` and `b` as a pair to compare |
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Marks `gt` as the result of a valid pair |
| gt | output | 1 | 1 when `a` is greater than `b` |

## Verification
The assertions check the following on every cycle:
- no node carries the illegal (1,1) code;
- a deferring output only comes from two deferring inputs, and an upper input that reports "greater" always survives its merge;
- in the pipelined modes, `gt` and `out_valid` match an independent delay line fed with `a > b` and `in_valid`.

The bench's scenarios are needed for the rest:
- that all 65536 operand pairs at WIDTH 8 give the right answer in all three timing modes;
- that bubbles in `in_valid` come out at the correct cycle;
- that the reset state is quiet.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Per-node code: gt = this group says a > b, defer = group is equal.
  typedef struct packed {
    logic gt;
    logic defer;
  } code_t;

  // Leaf code for one bit pair (R2).
  function automatic code_t leaf_code(input logic abit, input logic bbit);
    code_t r;
    r.gt    = abit & ~bbit;
    r.defer = ~(abit ^ bbit);
    return r;
  endfunction

  // Merge of an upper and lower group (R3).
  function automatic code_t merge_code(input code_t hi, input code_t lo);
    return hi.defer ? lo : hi;
  endfunction

  // Whether merge level lvl is followed by a register.
  function automatic bit stage_has_reg(input int mode, input int lvl, input int levels);
    bit r;
    case (mode)
      1:       r = 1'b1;
      2:       r = ((lvl % 2) == 1) || (lvl == levels - 1);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Number of register stages, i.e. the latency in cycles.
  function automatic int stage_count(input int mode, input int levels);
    int n;
    n = 0;
    for (int l = 0; l < levels; l++) begin
      if (stage_has_reg(mode, l, levels)) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/cmp_leaf_row.sv
module cmp_leaf_row
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output code_t [WIDTH-1:0] codes
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign codes[i] = leaf_code(a[i], b[i]);

    // R2: a leaf never emits greater and defer together
    always_comb begin
      if (!$isunknown({a[i], b[i]})) begin
        a_r2_leaf_legal: assert (!(codes[i].gt && codes[i].defer));
      end
    end
  end

endmodule

// File: rtl/cmp_merge_level.sv
module cmp_merge_level
  import cmp_pkg::*;
#(
  parameter int IN_CNT = 8,
  localparam int OUT_CNT = IN_CNT / 2
) (
  input  code_t [IN_CNT-1:0]  codes_in,
  output code_t [OUT_CNT-1:0] codes_out
);

  code_t [OUT_CNT-1:0] upper_code;
  code_t [OUT_CNT-1:0] lower_code;
  logic  [OUT_CNT-1:0] take_lower;

  for (genvar j = 0; j < OUT_CNT; j++) begin : g_node
    assign upper_code[j] = codes_in[2*j+1];
    assign lower_code[j] = codes_in[2*j];
    assign take_lower[j] = upper_code[j].defer;
    assign codes_out[j]  = merge_code(upper_code[j], lower_code[j]);

    always_comb begin
      if (!$isunknown({upper_code[j], lower_code[j]})) begin
        // R4: equality only survives if both halves are equal
        a_r4_defer_chain: assert (!codes_out[j].defer ||
                                  (upper_code[j].defer && lower_code[j].defer));
        // R3: an upper half that wins by itself is never overridden
        a_r3_upper_wins: assert (!upper_code[j].gt || (codes_out[j].gt && !take_lower[j]));
        // R2: no illegal code leaves a merge node
        a_r2_code_legal: assert (!(codes_out[j].gt && codes_out[j].defer));
      end
    end
  end

endmodule

// File: rtl/cmp_pipe_reg.sv
module cmp_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_d,
  input  logic [W-1:0] dat_d,
  output logic         vld_q,
  output logic [W-1:0] dat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

endmodule

// File: rtl/tree_gt_cmp.sv
module tree_gt_cmp
  import cmp_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PIPE_MODE = 1,
  localparam int LEVELS   = $clog2(WIDTH),
  localparam int LAT      = stage_count(PIPE_MODE, LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             out_valid,
  output logic             gt
);

  if ((WIDTH < 2) || ((1 << LEVELS) != WIDTH)) begin : g_bad_width
    $error("tree_gt_cmp: WIDTH must be a power of two, at least 2");
  end

  code_t [WIDTH-1:0] leaf_codes;

  cmp_leaf_row #(.WIDTH(WIDTH)) u_leaves (
    .a     (a),
    .b     (b),
    .codes (leaf_codes)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : lvl
    localparam int CNT_IN  = WIDTH >> l;
    localparam int CNT_OUT = CNT_IN / 2;

    code_t [CNT_IN-1:0]  d_in;
    logic                v_in;
    code_t [CNT_OUT-1:0] merged;
    code_t [CNT_OUT-1:0] d_out;
    logic                v_out;

    if (l == 0) begin : g_src_leaf
      assign d_in = leaf_codes;
      assign v_in = in_valid;
    end else begin : g_src_prev
      assign d_in = lvl[l-1].d_out;
      assign v_in = lvl[l-1].v_out;
    end

    cmp_merge_level #(.IN_CNT(CNT_IN)) u_merge (
      .codes_in  (d_in),
      .codes_out (merged)
    );

    if (stage_has_reg(PIPE_MODE, l, LEVELS)) begin : g_reg
      cmp_pipe_reg #(.W($bits(code_t) * CNT_OUT)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_d (v_in),
        .dat_d (merged),
        .vld_q (v_out),
        .dat_q (d_out)
      );
    end else begin : g_wire
      assign d_out = merged;
      assign v_out = v_in;
    end
  end

  code_t root_code;
  assign root_code = lvl[LEVELS-1].d_out[0];
  assign gt        = root_code.gt;
  assign out_valid = lvl[LEVELS-1].v_out;

  // R4: a deferring root always means "not greater"
  always_comb begin
    if (!$isunknown(root_code)) begin
      a_r4_root_equal: assert (!(root_code.defer && gt));
    end
  end

  if (LAT == 0) begin : g_chk_comb
    // R1/R5: combinational result equals the plain comparison
    always_comb begin
      if (in_valid === 1'b1 && !$isunknown({a, b})) begin
        a_r1_gt_comb: assert (gt == (a > b));
      end
    end
  end else begin : g_chk_pipe
    logic [LAT-1:0] ref_v;
    logic [LAT-1:0] ref_g;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_v <= '0;
        ref_g <= '0;
      end else begin
        ref_v[0] <= in_valid;
        ref_g[0] <= (a > b);
        for (int k = 1; k < LAT; k++) begin
          ref_v[k] <= ref_v[k-1];
          ref_g[k] <= ref_g[k-1];
        end
      end
    end

    // R1/R6/R7: pipelined result matches a delayed reference
    a_r1_gt_ref: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (gt == ref_g[LAT-1]));

    // R8: valid travels with the data
    a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == ref_v[LAT-1]);
  end

endmodule

// File: tb/tree_gt_cmp_test.sv
module tree_gt_cmp_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 12;

  // {a, b, expected gt}, written by hand from R1..R4
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b0},
    {8'hFF, 8'hFF, 1'b0},
    {8'h5A, 8'h5A, 1'b0},
    {8'h01, 8'h00, 1'b1},
    {8'h00, 8'h01, 1'b0},
    {8'h80, 8'h7F, 1'b1},
    {8'h7F, 8'h80, 1'b0},
    {8'h0F, 8'h10, 1'b0},
    {8'hA5, 8'hA4, 1'b1},
    {8'hFF, 8'h00, 1'b1},
    {8'h00, 8'hFF, 1'b0},
    {8'h3C, 8'h3B, 1'b1}
  };

  function automatic string vec_tag(input int i);
    string s;
    if (i < 3)       s = "R4";
    else if (i < 5)  s = "R2";
    else if (i < 8)  s = "R3";
    else if (i == 8) s = "R2";
    else if (i < 11) s = "R1";
    else             s = "R3";
    return s;
  endfunction

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;

  logic p1_v, p1_g, p2_v, p2_g, c_v, c_g;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic  hist_v [4];
  logic  hist_g [4];
  string hist_tag [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tree_gt_cmp #(.WIDTH(W), .PIPE_MODE(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(p1_v), .gt(p1_g)
  );

  tree_gt_cmp #(.WIDTH(W), .PIPE_MODE(2)) uut_half (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(p2_v), .gt(p2_g)
  );

  tree_gt_cmp #(.WIDTH(W), .PIPE_MODE(0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(c_v), .gt(c_g)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h t=%0t)",
               req, act, exp, a, b, $time);
    end
  endtask

  // One cycle: check pipelined outputs, drive a new pair, check the comb copy.
  task automatic step(input logic [W-1:0] av, input logic [W-1:0] bv,
                      input logic v, input logic expv, input string tag);
    @(negedge clk);
    // mode 1: latency 3 (R6)
    chk(p1_v == hist_v[2], "R8 valid mode1", p1_v, hist_v[2]);
    if (hist_v[2]) chk(p1_g == hist_g[2], {"R6 ", hist_tag[2]}, p1_g, hist_g[2]);
    // mode 2: latency 2 (R7)
    chk(p2_v == hist_v[1], "R8 valid mode2", p2_v, hist_v[1]);
    if (hist_v[1]) chk(p2_g == hist_g[1], {"R7 ", hist_tag[1]}, p2_g, hist_g[1]);
    a = av;
    b = bv;
    in_valid = v;
    for (int k = 3; k > 0; k--) begin
      hist_v[k]   = hist_v[k-1];
      hist_g[k]   = hist_g[k-1];
      hist_tag[k] = hist_tag[k-1];
    end
    hist_v[0]   = v;
    hist_g[0]   = expv;
    hist_tag[0] = tag;
    #1;
    chk(c_g == expv, {"R5 ", tag}, c_g, expv);
    chk(c_v == v, "R5 valid", c_v, v);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      hist_v[k] = 1'b0;
      hist_g[k] = 1'b0;
      hist_tag[k] = "";
    end
    repeat (3) @(negedge clk);
    // R8: quiet outputs under reset
    chk(p1_v == 1'b0, "R8 reset mode1", p1_v, 0);
    chk(p2_v == 1'b0, "R8 reset mode2", p2_v, 0);
    // R4: equal zero operands give 0 even in reset
    chk(c_g == 1'b0, "R4 reset comb", c_g, 0);
    rst_n = 1'b1;

    // directed vector table
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][16:9], VEC[i][8:1], 1'b1, VEC[i][0], vec_tag(i));
    end

    // R8: bubbles in the valid stream
    step(8'h40, 8'h20, 1'b0, 1'b1, "R8");
    step(8'h20, 8'h40, 1'b1, 1'b0, "R8");
    step(8'hC0, 8'h3F, 1'b0, 1'b1, "R8");
    step(8'h81, 8'h80, 1'b1, 1'b1, "R8");

    // R1: every operand pair, back to back, with periodic bubbles
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        step(ia[W-1:0], ib[W-1:0], ((ia + ib) % 13) != 12, ia > ib, "R1");
      end
    end

    // flush the pipelines
    for (int k = 0; k < 4; k++) step(8'h00, 8'h00, 1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule